// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the clocked controller that sits between a volatile word array and its shadow nonvolatile array. It copies the whole volatile array into the shadow array (a store) and copies it back (a recall), one word per clock. It emits an address and a write strobe for whichever array is the target. It decides when each copy runs from four things: a digital supply-good flag from an external comparator, a shared open-drain store/busy line, a software store request and a software recall request.

When the supply becomes good, the block recalls the array. When the supply fails, it stores the array automatically and pulls the shared line low for a fixed window. Any agent on the shared line can force a store by holding the line low long enough. The block then keeps the line low itself for as long as that store runs. After a requested store, normal memory access stays locked out for a recovery window. While the supply is bad, the access-inhibit output blocks writes, and it also stays high whenever the block is not idle. Every time limit is a parameter counted in clock cycles.

Top module: `nv_store_recall_seq`

## Requirements
- R1: During and right after reset with the supply flag low, `busy`, `sbl_drive_low`, `store_wr` and `recall_wr` are 0, `copy_addr` is 0 and `access_inhibit` is 1.
- R2: When `supply_ok` is sampled high while powered off, the next cycle starts a recall. The recall asserts `busy` and `recall_wr` for exactly 2^ADDR_W cycles. After that the block is idle with `access_inhibit` low.
- R3: When `supply_ok` is sampled low while idle or recovering, the next cycle starts an automatic store. This store asserts `store_wr` for 2^ADDR_W cycles and pulls the line low (`sbl_drive_low`=1) for exactly AUTO_DRIVE_CYC cycles from its first cycle. Afterwards the block stays inhibited and not busy until the supply returns, and then it recalls.
- R4: While idle with the supply good, the line sampled low on MIN_PULSE_CYC consecutive clocks starts a store on the next cycle. The line must be low for that long without the block driving it. With the defaults, this latency stays within 30 cycles (300 ns at 100 MHz). A shorter low pulse starts nothing.
- R5: During a store started by the line or by software, `sbl_drive_low` is 1 for every cycle of the copy. It is 0 whenever no store copy is running.
- R6: After a store started by the line or by software ends with the supply good, `access_inhibit` stays 1 with `busy` 0 for exactly RECOVER_CYC cycles, and then drops.
- R7: A one-cycle `sw_store_req` while idle starts a store on the next cycle. A one-cycle `sw_recall_req` while idle starts a recall on the next cycle.
- R8: Requests on the line or by software that arrive during a copy, during recovery or while the supply is low are dropped, not queued. No copy follows them.
- R9: `access_inhibit` is 1 in every cycle where `supply_ok` is 0, and in every cycle where the block is not idle.
- R10: `store_wr` and `recall_wr` are never 1 together. `busy` is 1 exactly when one of them is 1. `copy_addr` is 0 in the first cycle of a copy, rises by one each cycle, and ends at 2^ADDR_W-1.
- R11: Requests arriving in the same cycle are ranked: supply loss first, then a line or software store, then a software recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above switch threshold (synchronous) |
| sbl_line | input | 1 | Sampled level of the shared open-drain store/busy line (1 = released) |
| sw_store_req | input | 1 | Software store request, one-cycle pulse |
| sw_recall_req | input | 1 | Software recall request, one-cycle pulse |
| sbl_drive_low | output | 1 | Pull-down enable for the shared line |
| busy | output | 1 | A store or recall copy is running |
| access_inhibit | output | 1 | Normal memory access blocked |
| copy_addr | output | ADDR_W | Word address of the current copy step |
| store_wr | output | 1 | Write strobe into the nonvolatile array |
| recall_wr | output | 1 | Write strobe into the volatile array |

## Verification
The assertions check the following on every cycle:
- The two strobes never overlap, and `busy` matches the strobes.
- The copy address starts at zero and steps by one.
- The line is pulled low only during a store.
- Inhibit is forced whenever the supply is low.
- A supply drop while idle starts a pulled-down store on the next cycle.
- Inhibit persists once a store ends.

Only the bench scenarios can show these properties:
- The exact copy length, the auto-drive window length and the recovery length, each measured against its boundary.
- That a low pulse one cycle short is ignored.
- That requests during copies, recovery or power-off are dropped rather than queued.
- The ranking of requests that arrive together.

// File: rtl/nvseq_pkg.sv
// Package: shared types for the store/recall sequencer.
package nvseq_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        SEQ_OFF     = 3'd0,
        SEQ_RECALL  = 3'd1,
        SEQ_IDLE    = 3'd2,
        SEQ_STORE   = 3'd3,
        SEQ_RECOVER = 3'd4
    } seq_state_t;

    // Origin of the running store
    typedef enum logic {
        SRC_AUTO = 1'b0,
        SRC_REQ  = 1'b1
    } store_src_t;

endpackage

// File: rtl/nvseq_pulse_qual.sv
// Module: nvseq_pulse_qual
// Qualifies a low level on the shared line. It fires in the cycle that the
// line is seen low for the MIN_PULSE-th consecutive time while enabled.
// Assumes: line_low is already synchronous to clk. Enable drops once a store
// starts, so fire is a single-cycle pulse.
module nvseq_pulse_qual #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_low,
    output logic fire
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    logic [CNT_W-1:0] low_cnt;

    // Count consecutive qualified low samples, saturating at MIN_PULSE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!enable || !line_low) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_W'(MIN_PULSE)) begin
            low_cnt <= low_cnt + CNT_W'(1);
        end
    end

    // Fire on the sample that completes the minimum width
    always_comb begin
        fire = enable && line_low && (low_cnt == CNT_W'(MIN_PULSE - 1));
    end
endmodule

// File: rtl/nvseq_window_timer.sv
// Module: nvseq_window_timer
// One-shot down counter. After load it reports running for CYCLES cycles.
// Assumes: a reload restarts the window at full length.
module nvseq_window_timer #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic running
);
    localparam int CNT_W = $clog2(CYCLES + 2);

    logic [CNT_W-1:0] remain;

    // Load the window length, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CNT_W'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // Window is open while cycles remain
    always_comb begin
        running = (remain != '0);
    end
endmodule

// File: rtl/nvseq_copy_engine.sv
// Module: nvseq_copy_engine
// Walks the word address over the whole array, one word per clock.
// A start pulse makes it active from the next cycle at address 0. last marks
// the final word.
// Assumes: start is not raised while active.
module nvseq_copy_engine #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              active,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    // Address sweep and activity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            addr   <= '0;
        end else if (start) begin
            active <= 1'b1;
            addr   <= '0;
        end else if (active) begin
            if (addr == TOP_ADDR) begin
                active <= 1'b0;
                addr   <= '0;
            end else begin
                addr <= addr + ADDR_W'(1);
            end
        end
    end

    // Final-word marker
    always_comb begin
        last = active && (addr == TOP_ADDR);
    end
endmodule

// File: rtl/nv_store_recall_seq.sv
// Module: nv_store_recall_seq (top)
// Sequences power-up recall, automatic store on supply loss, store on the
// shared line or by software, software recall, and the post-store recovery
// lockout.
// Assumes: all inputs are synchronous to clk. AUTO_DRIVE_CYC <= 2**ADDR_W and
// RECOVER_CYC >= 1. With the defaults, MIN_PULSE_CYC + 1 cycles at 100 MHz
// keeps the busy latency under 300 ns.
module nv_store_recall_seq #(
    parameter int ADDR_W         = 11,
    parameter int MIN_PULSE_CYC  = 2,
    parameter int AUTO_DRIVE_CYC = 100,
    parameter int RECOVER_CYC    = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              sbl_line,
    input  logic              sw_store_req,
    input  logic              sw_recall_req,
    output logic              sbl_drive_low,
    output logic              busy,
    output logic              access_inhibit,
    output logic [ADDR_W-1:0] copy_addr,
    output logic              store_wr,
    output logic              recall_wr
);
    import nvseq_pkg::*;

    localparam int RECOVER_LOAD = RECOVER_CYC - 1;

    seq_state_t state, state_nx;
    store_src_t src, src_nx;

    logic hw_fire, hw_enable;
    logic copy_start, copy_active, copy_last;
    logic auto_load, auto_running;
    logic recov_load, recov_running;

    // Shared-line request qualifier
    nvseq_pulse_qual #(.MIN_PULSE(MIN_PULSE_CYC)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (hw_enable),
        .line_low (!sbl_line),
        .fire     (hw_fire)
    );

    // Array address sweep
    nvseq_copy_engine #(.ADDR_W(ADDR_W)) u_copy (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (copy_start),
        .active (copy_active),
        .addr   (copy_addr),
        .last   (copy_last)
    );

    // Pull-down window for the automatic store
    nvseq_window_timer #(.CYCLES(AUTO_DRIVE_CYC)) u_auto_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (auto_load),
        .running (auto_running)
    );

    // Post-store recovery window
    nvseq_window_timer #(.CYCLES(RECOVER_LOAD)) u_recov_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (recov_load),
        .running (recov_running)
    );

    // Line requests count only while idle with good supply
    always_comb begin
        hw_enable = (state == SEQ_IDLE) && supply_ok;
    end

    // Next-state decision, ranked: supply loss, store request, recall request
    always_comb begin
        state_nx   = state;
        src_nx     = src;
        copy_start = 1'b0;
        auto_load  = 1'b0;
        recov_load = 1'b0;
        unique case (state)
            SEQ_OFF: begin
                if (supply_ok) begin
                    state_nx   = SEQ_RECALL;
                    copy_start = 1'b1;
                end
            end
            SEQ_RECALL: begin
                if (copy_last) state_nx = SEQ_IDLE;
            end
            SEQ_IDLE: begin
                if (!supply_ok) begin
                    state_nx   = SEQ_STORE;
                    src_nx     = SRC_AUTO;
                    copy_start = 1'b1;
                    auto_load  = 1'b1;
                end else if (hw_fire || sw_store_req) begin
                    state_nx   = SEQ_STORE;
                    src_nx     = SRC_REQ;
                    copy_start = 1'b1;
                end else if (sw_recall_req) begin
                    state_nx   = SEQ_RECALL;
                    copy_start = 1'b1;
                end
            end
            SEQ_STORE: begin
                if (copy_last) begin
                    if (src == SRC_AUTO || !supply_ok) begin
                        state_nx = SEQ_OFF;
                    end else begin
                        state_nx   = SEQ_RECOVER;
                        recov_load = 1'b1;
                    end
                end
            end
            SEQ_RECOVER: begin
                if (!supply_ok) begin
                    state_nx   = SEQ_STORE;
                    src_nx     = SRC_AUTO;
                    copy_start = 1'b1;
                    auto_load  = 1'b1;
                end else if (!recov_running) begin
                    state_nx = SEQ_IDLE;
                end
            end
            default: state_nx = SEQ_OFF;
        endcase
    end

    // State and store-origin registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_OFF;
            src   <= SRC_AUTO;
        end else begin
            state <= state_nx;
            src   <= src_nx;
        end
    end

    // Output decode
    always_comb begin
        busy           = (state == SEQ_RECALL) || (state == SEQ_STORE);
        access_inhibit = (state != SEQ_IDLE) || !supply_ok;
        store_wr       = copy_active && (state == SEQ_STORE);
        recall_wr      = copy_active && (state == SEQ_RECALL);
        sbl_drive_low  = auto_running || ((state == SEQ_STORE) && (src == SRC_REQ));
    end
endmodule

// File: rtl/nvseq_checker.sv
// Module: nvseq_checker
// Cycle-by-cycle properties on the sequencer ports. It is bound into the top.
module nvseq_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              sbl_drive_low,
    input logic              busy,
    input logic              access_inhibit,
    input logic [ADDR_W-1:0] copy_addr,
    input logic              store_wr,
    input logic              recall_wr
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_wr && recall_wr));

    // R10
    busy_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (store_wr || recall_wr));

    // R10
    strobe_has_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_wr || recall_wr) |-> busy);

    // R10
    addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (copy_addr == '0));

    // R10
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (copy_addr == $past(copy_addr) + ADDR_W'(1)));

    // R5
    drive_in_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sbl_drive_low |-> store_wr);

    // R9
    low_supply_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> access_inhibit);

    // R3
    auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(supply_ok) && !busy && !$past(access_inhibit))
            |=> (busy && store_wr && sbl_drive_low));

    // R6
    post_store_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(store_wr)) |-> access_inhibit);
endmodule

bind nv_store_recall_seq nvseq_checker #(.ADDR_W(ADDR_W)) u_nvseq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .sbl_drive_low  (sbl_drive_low),
    .busy           (busy),
    .access_inhibit (access_inhibit),
    .copy_addr      (copy_addr),
    .store_wr       (store_wr),
    .recall_wr      (recall_wr)
);

// File: tb/nv_store_recall_seq_test.sv
// Bench: directed corners plus seeded random requests on the sequencer.
module nv_store_recall_seq_test;
    localparam int AW    = 7;
    localparam int N     = 1 << AW;
    localparam int MINP  = 2;
    localparam int AUTOC = 20;
    localparam int RECC  = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic supply_ok = 1'b0, tb_pull = 1'b0, sw_store = 1'b0, sw_recall = 1'b0;
    logic sbl_line, sbl_drive_low, busy, access_inhibit, store_wr, recall_wr;
    logic [AW-1:0] copy_addr;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Wired-AND of the open-drain line with a pull-up
    assign sbl_line = !(tb_pull || sbl_drive_low);

    nv_store_recall_seq #(.ADDR_W(AW), .MIN_PULSE_CYC(MINP),
        .AUTO_DRIVE_CYC(AUTOC), .RECOVER_CYC(RECC)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sbl_line(sbl_line),
        .sw_store_req(sw_store), .sw_recall_req(sw_recall),
        .sbl_drive_low(sbl_drive_low), .busy(busy), .access_inhibit(access_inhibit),
        .copy_addr(copy_addr), .store_wr(store_wr), .recall_wr(recall_wr));

    always #5 clk = ~clk;

    function automatic int exp_drive(input bit is_auto);
        return is_auto ? AUTOC : N;
    endfunction

    function automatic bit exp_fires(input int len);
        return len >= MINP;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Follow a copy from its first cycle, then check strobes, address and length
    task automatic run_copy(input bit exp_store, input bit poke, input string req,
                            output int len, output int drv);
        int bad_strobe = 0, bad_addr = 0;
        len = 0; drv = 0;
        while (busy && len < 4 * N) begin
            if (store_wr !== exp_store || recall_wr !== !exp_store) bad_strobe++;
            if (copy_addr !== AW'(len)) bad_addr++;
            if (sbl_drive_low) drv++;
            if (poke && len == 3) begin sw_store = 1; sw_recall = 1; tb_pull = 1; end
            if (poke && len == 4 + MINP) begin sw_store = 0; sw_recall = 0; tb_pull = 0; end
            step();
            len++;
        end
        sw_store = 0; sw_recall = 0; tb_pull = 0;
        check(bad_strobe == 0, {req, " R10 strobe"}, bad_strobe, 0);
        check(bad_addr == 0, {req, " R10 addr"}, bad_addr, 0);
        check(len == N, {req, " copy length"}, len, N);
    endtask

    // Count the recovery lockout; optionally poke a recall during it
    task automatic run_recovery(input bit poke);
        int n = 0;
        while (access_inhibit && !busy && n < 1000) begin
            sw_recall = poke && (n == 2);
            step();
            n++;
        end
        sw_recall = 0;
        check(n == RECC, "R6 recovery length", n, RECC);
        repeat (3) step();
        check(!busy && !access_inhibit, "R8 no queued request after recovery", busy, 0);
    endtask

    task automatic power_up();
        int len, drv;
        supply_ok = 1;
        step();
        check(busy && recall_wr, "R2 recall starts", busy, 1);
        run_copy(1'b0, 1'b0, "R2", len, drv);
        check(!access_inhibit, "R2 idle after recall", access_inhibit, 0);
        check(drv == 0, "R5 no drive in recall", drv, 0);
    endtask

    task automatic auto_store(input bit with_sw);
        int len, drv;
        supply_ok = 0;
        sw_store  = with_sw;
        #1;
        check(access_inhibit, "R9 inhibit on low supply", access_inhibit, 1);
        step();
        sw_store = 0;
        check(busy && store_wr && sbl_drive_low, "R3 auto store starts", busy, 1);
        run_copy(1'b1, 1'b0, "R3", len, drv);
        check(drv == exp_drive(1), with_sw ? "R11 supply loss outranks store" : "R3 drive window",
              drv, exp_drive(1));
        sw_store = 1;
        step();
        sw_store = 0;
        repeat (4) step();
        check(!busy && access_inhibit, "R8 request ignored while supply low", busy, 0);
        power_up();
    endtask

    // Requested store: check drive, length and recovery
    task automatic req_store_body(input bit poke_rec);
        int len, drv;
        check(busy && store_wr, "R7 requested store running", busy, 1);
        run_copy(1'b1, 1'b0, "R5", len, drv);
        check(drv == exp_drive(0), "R5 drive whole store", drv, exp_drive(0));
        run_recovery(poke_rec);
    endtask

    task automatic hw_pulse(input int plen);
        int lat = 0;
        tb_pull = 1;
        for (int i = 0; i < plen && !busy; i++) begin
            step();
            if (busy && lat == 0) lat = i + 1;
        end
        tb_pull = 0;
        if (exp_fires(plen)) begin
            check(lat == MINP && lat <= 30, "R4 line store latency", lat, MINP);
            req_store_body(1'b0);
        end else begin
            repeat (3) step();
            check(!busy && !access_inhibit, "R4 short pulse ignored", busy, 0);
        end
    endtask

    task automatic sw_req(input bit do_store, input bit do_recall);
        int len, drv;
        sw_store = do_store; sw_recall = do_recall;
        step();
        sw_store = 0; sw_recall = 0;
        if (do_store) begin
            req_store_body(1'b0);
        end else begin
            check(busy && recall_wr, "R7 sw recall starts", busy, 1);
            run_copy(1'b0, 1'b0, "R7", len, drv);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int len, drv;
        void'($urandom(32'd20240611));
        repeat (3) step();
        check(!busy && !sbl_drive_low && !store_wr && !recall_wr && access_inhibit,
              "R1 in reset", busy, 0);
        rst_n = 1;
        repeat (3) step();
        check(!busy && !sbl_drive_low && copy_addr == '0 && access_inhibit,
              "R1 after reset", busy, 0);

        power_up();
        // R8: requests during a recall are dropped
        sw_recall = 1; step(); sw_recall = 0;
        run_copy(1'b0, 1'b1, "R8 poke during recall", len, drv);
        repeat (4) step();
        check(!busy, "R8 not queued after copy", busy, 0);

        hw_pulse(MINP - 1);
        hw_pulse(MINP);
        hw_pulse(MINP + 1);
        sw_req(1'b1, 1'b0);
        // Recall request during recovery is dropped
        sw_store = 1; step(); sw_store = 0;
        check(busy && store_wr, "R7 sw store starts", busy, 1);
        run_copy(1'b1, 1'b0, "R5", len, drv);
        run_recovery(1'b1);
        sw_req(1'b0, 1'b1);
        // R11: store outranks recall in the same cycle
        sw_store = 1; sw_recall = 1; step(); sw_store = 0; sw_recall = 0;
        check(store_wr && !recall_wr, "R11 store over recall", store_wr, 1);
        run_copy(1'b1, 1'b0, "R11", len, drv);
        // R3: supply loss during recovery starts an auto store
        repeat (2) step();
        auto_store(1'b0);
        auto_store(1'b1);

        for (int k = 0; k < 12; k++) begin
            int op = $urandom_range(0, 2);
            if (op == 0) hw_pulse($urandom_range(1, 4));
            else if (op == 1) sw_req(1'b1, 1'b0);
            else sw_req(1'b0, 1'b1);
        end
        auto_store(1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule